// File: doc/BRIEF.md
# Palette DAC Host Register File with Indirect Extended Access

This block is the byte-wide host side of a colour-lookup DAC that also draws a hardware cursor. The host addresses one of sixteen registers by a 2-bit port select combined with 2 extension bits. Behind those registers sit four command registers, a shared write address pointer and a read address pointer for the colour lookup table, a second pointer pair for the overscan and cursor colours, the pixel mask, the cursor position and a window into the two-plane cursor bitmap RAM. Colour entries are moved as three bytes in red, green, blue order. Each pointer steps to the next entry after the third byte.

Index 0xA normally returns a fixed status byte. When command register 0 bit 7 is set and the write pointer holds 1, the same index instead reaches a fourth command register. The two low bits of that register extend the write pointer to form the 10-bit cursor RAM address. Each cursor RAM access steps that full address, and the carry out of the 8-bit pointer ripples into those two bits. Reads are combinational: `rdata` shows the selected register while `rd_en` is high. Every side effect of an access, such as a pointer step or a byte-counter advance, happens at the clock edge that ends the access.

Top module: `ramdac_regfile`

## Requirements
- R1: The register index is {ext, sel}. Index 0x2 holds the pixel mask, 0x6 command 0, 0x8 command 1, 0x9 command 2, 0xC/0xD cursor X low/high and 0xE/0xF cursor Y low/high. A write stores the byte, and a read of the same index returns it. The high-position registers keep only bits [3:0] and read back with zero upper bits.
- R2: While `rd_en` is high, `rdata` presents the selected register in the same cycle. Any pointer or counter step caused by the read takes effect at the next rising clock edge.
- R3: Index 0xA selects command register 3 only when command 0 bit 7 is 1 and the write pointer equals 0x01. Otherwise a read returns STATUS_ID (default 0x2A) and a write changes nothing.
- R4: Index 0x1 moves lookup-table data. Writes collect red, green and blue bytes, store the entry at the write pointer (index 0x0) on the third byte, and then add one to that pointer, wrapping 0xFF to 0x00. Reads return red, green, blue of the entry at the read pointer (index 0x3) and then add one to it. Reading index 0x0 or 0x3 returns the pointer.
- R5: Writing either pointer of a colour unit returns both of that unit's byte counters to the red byte.
- R6: Index 0x4 is the colour write pointer, 0x5 the colour data and 0x7 the colour read pointer. Entries are numbered 0 to 3 (0 is the overscan colour, 1 to 3 are the cursor colours) and use the same three-byte sequencing as R4. The pointers wrap from 3 to 0.
- R7: Index 0xB reads or writes the cursor RAM byte at {command 3 bits [1:0], write pointer}. After each access the 10-bit address increments. A write pointer step from 0xFF to 0x00 increments command 3 bits [1:0], and the address wraps from 1023 to 0.
- R8: `cursor_mode` equals command 2 bits [1:0]. `cursor_en` is high exactly when that mode is non-zero. `cursor_64` equals command 3 bit 2.
- R9: `cursor_x` is {X high[3:0], X low} and `cursor_y` is {Y high[3:0], Y low}.
- R10: After reset the pixel mask is 0xFF and all other registers, pointers and counters are zero.
- R11: When `wr_en` and `rd_en` are high together, only the write takes effect, so an address steps once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Port select, low index bits |
| ext | input | 2 | Extension bits, high index bits |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pixel_mask | output | 8 | Pixel mask register |
| cursor_mode | output | 2 | Cursor mode from command 2 |
| cursor_en | output | 1 | Cursor mode is non-zero |
| cursor_64 | output | 1 | 64x64 cursor size selected |
| cursor_x | output | 12 | Cursor X position |
| cursor_y | output | 12 | Cursor Y position |

## Verification
The bench fills cursor RAM across the 0xFF/0x100 boundary and across the 1023/0 boundary, then reads command 3 back. A design that drops the carry, or that lets lookup-table writes carry, returns a wrong command 3 value or the wrong cursor byte. It writes index 0xA while the hidden register is locked, then unlocks it. A design that decodes the lock wrongly either changes command 3 or returns status when command 3 is expected. It abandons a half-written colour and reloads the pointer; a design that keeps the byte counter stores a rotated entry. It raises both strobes together on the cursor port; a design that honours both steps the address twice.

// File: rtl/ramdac_pkg.sv
package ramdac_pkg;

    typedef enum logic [3:0] {
        IDX_WADDR  = 4'h0,
        IDX_PAL    = 4'h1,
        IDX_PMASK  = 4'h2,
        IDX_RADDR  = 4'h3,
        IDX_CWADDR = 4'h4,
        IDX_CDATA  = 4'h5,
        IDX_CMD0   = 4'h6,
        IDX_CRADDR = 4'h7,
        IDX_CMD1   = 4'h8,
        IDX_CMD2   = 4'h9,
        IDX_STAT   = 4'hA,
        IDX_CRAM   = 4'hB,
        IDX_CXL    = 4'hC,
        IDX_CXH    = 4'hD,
        IDX_CYL    = 4'hE,
        IDX_CYH    = 4'hF
    } reg_idx_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef logic [1:0] byte_cnt_t;

    localparam byte_cnt_t LAST_BYTE = 2'd2;

    function automatic byte_cnt_t cnt_next(input byte_cnt_t c);
        return (c == LAST_BYTE) ? 2'd0 : c + 2'd1;
    endfunction

    function automatic logic [7:0] rgb_pick(input rgb_t e, input byte_cnt_t c);
        case (c)
            2'd0:    return e.r;
            2'd1:    return e.g;
            default: return e.b;
        endcase
    endfunction

endpackage

// File: rtl/ramdac_rgb_seq.sv
module ramdac_rgb_seq
    import ramdac_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wptr_ld,
    input  logic              rptr_ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [7:0]        wdata,
    input  logic              ext_inc,
    output logic [ADDR_W-1:0] wptr,
    output logic [ADDR_W-1:0] rptr,
    output logic [7:0]        rd_byte,
    output logic              carry
);
    localparam int DEPTH = 1 << ADDR_W;

    rgb_t            mem [DEPTH];
    byte_cnt_t       wcnt, rcnt;
    logic [7:0]      stg_r, stg_g;
    logic            commit;

    assign commit  = data_wr && (wcnt == LAST_BYTE);
    assign carry   = ext_inc && (wptr == {ADDR_W{1'b1}});
    assign rd_byte = rgb_pick(mem[rptr], rcnt);

    always_ff @(posedge clk) begin
        if (commit) mem[wptr] <= '{r: stg_r, g: stg_g, b: wdata};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            wcnt  <= '0;
            rcnt  <= '0;
            stg_r <= '0;
            stg_g <= '0;
        end else if (wptr_ld || rptr_ld) begin
            if (wptr_ld) wptr <= ld_val;
            if (rptr_ld) rptr <= ld_val;
            wcnt <= '0;
            rcnt <= '0;
        end else begin
            if (data_wr) begin
                if (wcnt == 2'd0) stg_r <= wdata;
                if (wcnt == 2'd1) stg_g <= wdata;
                wcnt <= cnt_next(wcnt);
            end
            if (commit || ext_inc) wptr <= wptr + 1'b1;
            if (data_rd) begin
                rcnt <= cnt_next(rcnt);
                if (rcnt == LAST_BYTE) rptr <= rptr + 1'b1;
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (wcnt != 2'd3) && (rcnt != 2'd3)); // R4

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wptr_ld || rptr_ld) |=> (wcnt == 2'd0) && (rcnt == 2'd0)); // R5

    AST_ENTRY_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !wptr_ld && !rptr_ld && wcnt == LAST_BYTE)
        |=> wptr == $past(wptr) + 1'b1); // R4

    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !wptr_ld && !rptr_ld && rcnt == LAST_BYTE)
        |=> rptr == $past(rptr) + 1'b1); // R4

endmodule

// File: rtl/ramdac_cursor_ram.sv
module ramdac_cursor_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/ramdac_regfile.sv
module ramdac_regfile
    import ramdac_pkg::*;
#(
    parameter int         PAL_AW    = 8,
    parameter int         COL_AW    = 2,
    parameter int         CUR_AW    = 10,
    parameter logic [7:0] STATUS_ID = 8'h2A,
    parameter logic [7:0] PMASK_RST = 8'hFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  sel,
    input  logic [1:0]  ext,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [7:0]  pixel_mask,
    output logic [1:0]  cursor_mode,
    output logic        cursor_en,
    output logic        cursor_64,
    output logic [11:0] cursor_x,
    output logic [11:0] cursor_y
);
    localparam int HI_W = CUR_AW - PAL_AW;

    reg_idx_e          idx;
    logic              wr, rd;
    logic [7:0]        cmd0, cmd1, cmd2, cmd3;
    logic [7:0]        xl, yl;
    logic [3:0]        xh, yh;
    logic [PAL_AW-1:0] pal_wptr, pal_rptr;
    logic [COL_AW-1:0] col_wptr, col_rptr;
    logic [7:0]        pal_byte, col_byte, cram_byte;
    logic              pal_carry;
    logic              hidden_sel, hi_wr, cur_acc;

    assign idx = reg_idx_e'({ext, sel});
    assign wr  = wr_en;
    assign rd  = rd_en && !wr_en;

    assign hidden_sel = cmd0[7] && (pal_wptr == PAL_AW'(1));
    assign hi_wr      = wr && (idx == IDX_STAT) && hidden_sel;
    assign cur_acc    = (wr || rd) && (idx == IDX_CRAM);

    ramdac_rgb_seq #(.ADDR_W(PAL_AW)) u_pal (
        .clk     (clk),
        .rst     (rst),
        .wptr_ld (wr && idx == IDX_WADDR),
        .rptr_ld (wr && idx == IDX_RADDR),
        .ld_val  (wdata[PAL_AW-1:0]),
        .data_wr (wr && idx == IDX_PAL),
        .data_rd (rd && idx == IDX_PAL),
        .wdata   (wdata),
        .ext_inc (cur_acc),
        .wptr    (pal_wptr),
        .rptr    (pal_rptr),
        .rd_byte (pal_byte),
        .carry   (pal_carry)
    );

    logic col_carry_unused;

    ramdac_rgb_seq #(.ADDR_W(COL_AW)) u_col (
        .clk     (clk),
        .rst     (rst),
        .wptr_ld (wr && idx == IDX_CWADDR),
        .rptr_ld (wr && idx == IDX_CRADDR),
        .ld_val  (wdata[COL_AW-1:0]),
        .data_wr (wr && idx == IDX_CDATA),
        .data_rd (rd && idx == IDX_CDATA),
        .wdata   (wdata),
        .ext_inc (1'b0),
        .wptr    (col_wptr),
        .rptr    (col_rptr),
        .rd_byte (col_byte),
        .carry   (col_carry_unused)
    );

    ramdac_cursor_ram #(.AW(CUR_AW)) u_cram (
        .clk   (clk),
        .we    (wr && idx == IDX_CRAM),
        .addr  ({cmd3[HI_W-1:0], pal_wptr}),
        .wdata (wdata),
        .rdata (cram_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd0       <= '0;
            cmd1       <= '0;
            cmd2       <= '0;
            cmd3       <= '0;
            pixel_mask <= PMASK_RST;
            xl         <= '0;
            xh         <= '0;
            yl         <= '0;
            yh         <= '0;
        end else begin
            if (wr) begin
                case (idx)
                    IDX_PMASK: pixel_mask <= wdata;
                    IDX_CMD0:  cmd0 <= wdata;
                    IDX_CMD1:  cmd1 <= wdata;
                    IDX_CMD2:  cmd2 <= wdata;
                    IDX_CXL:   xl <= wdata;
                    IDX_CXH:   xh <= wdata[3:0];
                    IDX_CYL:   yl <= wdata;
                    IDX_CYH:   yh <= wdata[3:0];
                    default: ;
                endcase
            end
            if (hi_wr) cmd3 <= wdata;
            else if (pal_carry) cmd3[HI_W-1:0] <= cmd3[HI_W-1:0] + 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (idx)
                IDX_WADDR:  rdata = 8'(pal_wptr);
                IDX_PAL:    rdata = pal_byte;
                IDX_PMASK:  rdata = pixel_mask;
                IDX_RADDR:  rdata = 8'(pal_rptr);
                IDX_CWADDR: rdata = 8'(col_wptr);
                IDX_CDATA:  rdata = col_byte;
                IDX_CMD0:   rdata = cmd0;
                IDX_CRADDR: rdata = 8'(col_rptr);
                IDX_CMD1:   rdata = cmd1;
                IDX_CMD2:   rdata = cmd2;
                IDX_STAT:   rdata = hidden_sel ? cmd3 : STATUS_ID;
                IDX_CRAM:   rdata = cram_byte;
                IDX_CXL:    rdata = xl;
                IDX_CXH:    rdata = {4'b0, xh};
                IDX_CYL:    rdata = yl;
                IDX_CYH:    rdata = {4'b0, yh};
                default:    rdata = '0;
            endcase
        end
    end

    assign cursor_mode = cmd2[1:0];
    assign cursor_en   = |cmd2[1:0];
    assign cursor_64   = cmd3[2];
    assign cursor_x    = {xh, xl};
    assign cursor_y    = {yh, yl};

    AST_CARRY_INTO_CMD3: assert property (@(posedge clk) disable iff (rst)
        (cur_acc && pal_wptr == {PAL_AW{1'b1}})
        |=> cmd3[HI_W-1:0] == $past(cmd3[HI_W-1:0]) + 1'b1); // R7

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr && idx == IDX_STAT && !hidden_sel) |=> $stable(cmd3)); // R3

    AST_CURSOR_STEP: assert property (@(posedge clk) disable iff (rst)
        (cur_acc && pal_wptr != {PAL_AW{1'b1}})
        |=> pal_wptr == $past(pal_wptr) + 1'b1); // R7

    AST_PAL_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (wr && idx == IDX_PAL) |=> $stable(cmd3)); // R7

endmodule

// File: tb/ramdac_regfile_tb.sv
module ramdac_regfile_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  sel = '0;
    logic [1:0]  ext = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  pixel_mask;
    logic [1:0]  cursor_mode;
    logic        cursor_en;
    logic        cursor_64;
    logic [11:0] cursor_x;
    logic [11:0] cursor_y;

    logic        mon_req = 1'b0;
    logic [7:0]  exp_q [$];
    string       tag_q [$];
    int          n_chk = 0;
    int          n_err = 0;

    localparam logic [7:0] STAT = 8'h2A;

    always #5 clk = ~clk;

    ramdac_regfile u_dut (
        .clk(clk), .rst(rst), .sel(sel), .ext(ext),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .pixel_mask(pixel_mask), .cursor_mode(cursor_mode),
        .cursor_en(cursor_en), .cursor_64(cursor_64),
        .cursor_x(cursor_x), .cursor_y(cursor_y)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [3:0] idx, input logic w, input logic r,
                      input logic [7:0] d, input logic [7:0] exp, input string tag);
        @(posedge clk);
        #1;
        sel   = idx[1:0];
        ext   = idx[3:2];
        wr_en = w;
        rd_en = r;
        wdata = d;
        mon_req = r && !w;
        if (r && !w) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        op(idx, 1'b1, 1'b0, d, 8'h00, "");
    endtask

    task automatic rd(input logic [3:0] idx, input logic [7:0] exp, input string tag);
        op(idx, 1'b0, 1'b1, 8'h00, exp, tag);
    endtask

    task automatic idle();
        op(4'h0, 1'b0, 1'b0, 8'h00, 8'h00, "");
    endtask

    // Scoreboard monitor: compare each read against the queued expectation.
    always @(negedge clk) begin
        if (mon_req && exp_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            check(32'(rdata), 32'(e), t);
        end
    end

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R10 reset state
        idle();
        check(32'(pixel_mask), 32'hFF, "R10 pixel mask");
        check(32'(cursor_x), 32'h0, "R10 cursor x");
        check(32'(cursor_mode), 32'h0, "R10 cursor mode");
        rd(4'h2, 8'hFF, "R10 pmask read");
        rd(4'h6, 8'h00, "R10 cmd0 read");
        rd(4'h0, 8'h00, "R10 wptr read");

        // R1 / R8 / R9 plain registers
        wr(4'h8, 8'h5A);
        wr(4'h2, 8'h3C);
        wr(4'h9, 8'h03);
        wr(4'hC, 8'h34);
        wr(4'hD, 8'hF7);
        wr(4'hE, 8'h9B);
        wr(4'hF, 8'h02);
        idle();
        check(32'(cursor_mode), 32'h3, "R8 cursor mode");
        check(32'(cursor_en), 32'h1, "R8 cursor enable");
        check(32'(cursor_x), 32'h734, "R9 cursor x");
        check(32'(cursor_y), 32'h29B, "R9 cursor y");
        check(32'(pixel_mask), 32'h3C, "R1 pixel mask port");
        rd(4'h8, 8'h5A, "R1 cmd1");
        rd(4'hD, 8'h07, "R1 x high masked");
        rd(4'hE, 8'h9B, "R1 y low");
        wr(4'h9, 8'h00);
        idle();
        check(32'(cursor_en), 32'h0, "R8 cursor disabled");

        // R4 lookup-table sequencing
        wr(4'h0, 8'h10);
        wr(4'h1, 8'h11); wr(4'h1, 8'h22); wr(4'h1, 8'h33);
        wr(4'h1, 8'h44); wr(4'h1, 8'h55); wr(4'h1, 8'h66);
        rd(4'h0, 8'h12, "R4 wptr advanced");
        wr(4'h3, 8'h10);
        rd(4'h1, 8'h11, "R4 red0"); rd(4'h1, 8'h22, "R4 green0"); rd(4'h1, 8'h33, "R4 blue0");
        rd(4'h1, 8'h44, "R4 red1"); rd(4'h1, 8'h55, "R4 green1"); rd(4'h1, 8'h66, "R4 blue1");
        rd(4'h3, 8'h12, "R4 rptr advanced");

        // R5 pointer write restarts the byte sequence
        wr(4'h0, 8'h20);
        wr(4'h1, 8'hAA);
        wr(4'h0, 8'h20);
        wr(4'h1, 8'h01); wr(4'h1, 8'h02); wr(4'h1, 8'h03);
        wr(4'h3, 8'h20);
        rd(4'h1, 8'h01, "R5 red after reload");
        wr(4'h3, 8'h20);
        rd(4'h1, 8'h01, "R5 read counter reset");
        rd(4'h1, 8'h02, "R5 green");
        rd(4'h1, 8'h03, "R5 blue");

        // R4 wrap 0xFF -> 0x00 with no carry into cmd3
        wr(4'h0, 8'hFF);
        wr(4'h1, 8'h0A); wr(4'h1, 8'h0B); wr(4'h1, 8'h0C);
        rd(4'h0, 8'h00, "R4 wptr wrap");

        // R6 colour entries wrap 3 -> 0
        wr(4'h4, 8'h03);
        wr(4'h5, 8'hE1); wr(4'h5, 8'hE2); wr(4'h5, 8'hE3);
        wr(4'h5, 8'hD1); wr(4'h5, 8'hD2); wr(4'h5, 8'hD3);
        rd(4'h4, 8'h01, "R6 colour wptr wrap");
        wr(4'h7, 8'h03);
        rd(4'h5, 8'hE1, "R6 entry3 red"); rd(4'h5, 8'hE2, "R6 entry3 green");
        rd(4'h5, 8'hE3, "R6 entry3 blue"); rd(4'h5, 8'hD1, "R6 entry0 red");
        rd(4'h5, 8'hD2, "R6 entry0 green"); rd(4'h5, 8'hD3, "R6 entry0 blue");
        rd(4'h7, 8'h01, "R6 colour rptr wrap");

        // R3 status vs hidden command 3
        wr(4'h0, 8'h01);
        rd(4'hA, STAT, "R3 status when locked");
        wr(4'hA, 8'h55);
        wr(4'h6, 8'h80);
        rd(4'hA, 8'h00, "R3 locked write ignored");
        wr(4'hA, 8'h04);
        rd(4'hA, 8'h04, "R3 cmd3 readback");
        idle();
        check(32'(cursor_64), 32'h1, "R8 cursor 64");
        wr(4'h0, 8'h00);
        rd(4'hA, STAT, "R3 status with pointer 0");

        // R7 cursor RAM carry across 0x0FF -> 0x100
        wr(4'h0, 8'hFE);
        wr(4'hB, 8'hA1); wr(4'hB, 8'hA2); wr(4'hB, 8'hA3);
        rd(4'h0, 8'h01, "R7 low pointer after carry");
        rd(4'hA, 8'h05, "R7 carry into cmd3");
        wr(4'hA, 8'h04);
        wr(4'h0, 8'hFE);
        rd(4'hB, 8'hA1, "R7 byte 0FE"); rd(4'hB, 8'hA2, "R7 byte 0FF");
        rd(4'hB, 8'hA3, "R7 byte 100");
        rd(4'hA, 8'h05, "R7 carry on reads");

        // R7 wrap 1023 -> 0
        wr(4'hA, 8'h07);
        wr(4'h0, 8'hFF);
        wr(4'hB, 8'hC5); wr(4'hB, 8'hC6);
        wr(4'h0, 8'h01);
        rd(4'hA, 8'h04, "R7 msb wrap");
        wr(4'hA, 8'h07);
        wr(4'h0, 8'hFF);
        rd(4'hB, 8'hC5, "R7 byte 3FF");
        rd(4'hB, 8'hC6, "R7 byte 000");

        // R11 simultaneous strobes: write only
        wr(4'h0, 8'h01);
        wr(4'hA, 8'h04);
        wr(4'h0, 8'h10);
        op(4'hB, 1'b1, 1'b1, 8'h77, 8'h00, "");
        rd(4'h0, 8'h11, "R11 single step");
        wr(4'h0, 8'h10);
        rd(4'hB, 8'h77, "R11 write landed");

        // R2 read side effect lands at the edge: pointer unchanged before it
        wr(4'h3, 8'h10);
        rd(4'h1, 8'h11, "R2 first byte");
        rd(4'h3, 8'h10, "R2 pointer before third byte");
        idle();
        idle();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule